// File: doc/BRIEF.md
# Command Interrupt-Bit Stall Controller

This block sits between a command word source and a packet-command decoder. Every 32-bit command word carries an interrupt flag in bit 31. The first time a flagged command arrives, the controller holds it back. It raises the INT and PIS status bits, moves its processing-state code to the stall value and records a one-bit loop-prevention flag. The source keeps the same word on its outputs because the command pointer does not advance.

When the host pulses `resume`, PIS drops and the controller returns to idle. The held word is then decoded again. Because the loop-prevention flag is set, the word goes to the decoder with bit 31 cleared and the flag is consumed. The command therefore runs once and does not stall again. The marker command, whose opcode sits in bits 30:24, skips the stall and runs at once.

The state machine has four named states:
- **IDLE** (code 0): ready to decode.
- **WAIT** (code 1): a command is present but its operand words are not yet available.
- **STALL** (code 2): the stall and decode code.
- **XFER** (code 3): the decoder is working on the command.

It has six named transitions:
- **IDLE→WAIT**: a word is present without its operands.
- **WAIT→IDLE**: the word was withdrawn.
- **IDLE/WAIT→STALL**: first sight of a flagged command.
- **IDLE/WAIT→XFER**: dispatch.
- **STALL→IDLE**: on `resume`.
- **XFER→IDLE**: on `exec_done`.

Top module: `cmd_intr_stall_ctrl`

## Requirements
- R1: After reset, `proc_state` is 0 (idle), `stat_int` and `stat_pis` are 0, `exec_en` is 0 and the loop-prevention flag is clear.
- R2: A present, ready word with bit 31 set, whose opcode (bits 30:24) is not 7'h31, with the flag clear, gives `exec_en`=0 in that cycle. On the next cycle it gives `proc_state`=2, `stat_int`=1 and `stat_pis`=1.
- R3: While `proc_state` is 2, `exec_en` stays 0 and the state holds until `resume`.
- R4: A `resume` pulse in the stall state makes `stat_pis` 0 and `proc_state` 0 on the next cycle, and leaves `stat_int` unchanged.
- R5: After resume, the same flagged word is decoded again. It dispatches with `exec_en`=1 and `cmd_out` equal to the word with bit 31 cleared, and it does not stall again.
- R6: A ready word with bit 31 clear dispatches in the same cycle with `cmd_out` equal to the word, and `proc_state` is 3 on the next cycle.
- R7: A marker word (opcode 7'h31) dispatches at once even with bit 31 set. `cmd_out` is the unmodified word and INT/PIS are untouched.
- R8: A present word with `words_ready`=0 gives `proc_state`=1 and no dispatch. Once `words_ready` rises, the word is decoded in that cycle.
- R9: In state 3, `exec_done` returns `proc_state` to 0 on the next cycle.
- R10: `int_clr` clears `stat_int` on the next cycle, except when a stall entry happens in the same cycle; then `stat_int` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command word is presented |
| cmd_word | input | 32 | Command word; bit 31 is the interrupt flag, bits 30:24 the opcode |
| words_ready | input | 1 | Operand words for the presented command are available |
| resume | input | 1 | One-cycle host pulse ending a stall |
| int_clr | input | 1 | One-cycle pulse clearing the INT status bit |
| exec_done | input | 1 | Decoder has finished the dispatched command |
| cmd_out | output | 32 | Word passed to the decoder, interrupt bit masked on re-decode |
| exec_en | output | 1 | Dispatch strobe; also advances the command pointer |
| proc_state | output | 2 | Processing-state code: 0 idle, 1 wait, 2 stall, 3 transfer |
| stat_int | output | 1 | INT status bit |
| stat_pis | output | 1 | PIS status bit |

## Verification
Two functions can fall in the same cycle: the host clearing INT and a new flagged command entering the stall. The bench provokes this by holding `int_clr` high in the cycle where a fresh flagged word is first decoded. It then expects INT to read 1 on the next cycle, because the set wins. The bench also sweeps every opcode with the flag both clear and set. For each case it works out arithmetically whether the word is a marker, whether it must stall, and what masked word must appear after resume.

// File: rtl/cis_pkg.sv
package cis_pkg;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_WAIT  = 2'd1,
        PS_STALL = 2'd2,
        PS_XFER  = 2'd3
    } pstate_e;

    typedef struct packed {
        logic flagged;
        logic is_mark;
        logic want_stall;
        logic consume;
    } dec_s;

endpackage

// File: rtl/cis_decode.sv
module cis_decode
    import cis_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int INTR_BIT = 31,
    parameter int OP_LSB   = 24,
    parameter int OP_W     = 7,
    parameter logic [OP_W-1:0] MARK_OP = 7'h31
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic              loop_flag,
    output dec_s              dec,
    output logic [WORD_W-1:0] word_out
);
    localparam logic [WORD_W-1:0] INTR_MASK = ~(WORD_W'(1) << INTR_BIT);

    logic [OP_W-1:0] opcode;

    generate
        if (OP_W > 0) begin : g_op
            assign opcode = word_in[OP_LSB +: OP_W];
        end else begin : g_noop
            assign opcode = '0;
        end
    endgenerate

    always_comb begin
        dec.flagged    = word_in[INTR_BIT];
        dec.is_mark    = (opcode == MARK_OP);
        dec.want_stall = dec.flagged && !dec.is_mark && !loop_flag;
        dec.consume    = dec.flagged && !dec.is_mark && loop_flag;
        word_out       = dec.consume ? (word_in & INTR_MASK) : word_in;
    end
endmodule

// File: rtl/cis_status.sv
module cis_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_stall,
    input  logic clr_pis,
    input  logic int_clr,
    input  logic consume,
    output logic loop_q,
    output logic int_q,
    output logic pis_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loop_q <= 1'b0;
            int_q  <= 1'b0;
            pis_q  <= 1'b0;
        end else begin
            if (set_stall)
                loop_q <= 1'b1;
            else if (consume)
                loop_q <= 1'b0;

            if (set_stall)
                int_q <= 1'b1;
            else if (int_clr)
                int_q <= 1'b0;

            if (set_stall)
                pis_q <= 1'b1;
            else if (clr_pis)
                pis_q <= 1'b0;
        end
    end

    // R2
    stall_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_stall |=> (int_q && pis_q && loop_q));

    // R5
    consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !set_stall) |=> !loop_q);

    // R4
    pis_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pis && !set_stall) |=> !pis_q);

    // R10
    int_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_clr && !set_stall) |=> !int_q);
endmodule

// File: rtl/cis_fsm.sv
module cis_fsm
    import cis_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cmd_valid,
    input  logic    words_ready,
    input  logic    resume,
    input  logic    exec_done,
    input  logic    want_stall,
    output pstate_e state_q,
    output logic    exec_en,
    output logic    stall_go,
    output logic    leave_stall
);
    pstate_e state_d;
    logic    can_decode;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= PS_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        can_decode  = 1'b0;
        state_d     = state_q;
        unique case (state_q)
            PS_IDLE, PS_WAIT: begin
                if (cmd_valid && words_ready) begin
                    can_decode = 1'b1;
                    state_d    = want_stall ? PS_STALL : PS_XFER;
                end else if (cmd_valid) begin
                    state_d = PS_WAIT;
                end else begin
                    state_d = PS_IDLE;
                end
            end
            PS_STALL: begin
                if (resume)
                    state_d = PS_IDLE;
            end
            PS_XFER: begin
                if (exec_done)
                    state_d = PS_IDLE;
            end
            default: state_d = PS_IDLE;
        endcase
    end

    always_comb begin
        exec_en     = can_decode && !want_stall;
        stall_go    = can_decode && want_stall;
        leave_stall = (state_q == PS_STALL) && resume;
    end

    // R3
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_STALL) |-> !exec_en);

    // R4
    resume_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_STALL && resume) |=> (state_q == PS_IDLE));

    // R9
    xfer_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_XFER && exec_done) |=> (state_q == PS_IDLE));

    // R6
    dispatch_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_en |=> (state_q == PS_XFER));
endmodule

// File: rtl/cmd_intr_stall_ctrl.sv
module cmd_intr_stall_ctrl
    import cis_pkg::*;
#(
    parameter int WORD_W   = 32,
    parameter int INTR_BIT = 31,
    parameter int OP_LSB   = 24,
    parameter int OP_W     = 7,
    parameter logic [OP_W-1:0] MARK_OP = 7'h31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [WORD_W-1:0] cmd_word,
    input  logic              words_ready,
    input  logic              resume,
    input  logic              int_clr,
    input  logic              exec_done,
    output logic [WORD_W-1:0] cmd_out,
    output logic              exec_en,
    output logic [1:0]        proc_state,
    output logic              stat_int,
    output logic              stat_pis
);
    dec_s    dec;
    pstate_e state_q;
    logic    loop_q;
    logic    stall_go;
    logic    leave_stall;

    cis_decode #(
        .WORD_W(WORD_W), .INTR_BIT(INTR_BIT), .OP_LSB(OP_LSB),
        .OP_W(OP_W), .MARK_OP(MARK_OP)
    ) u_dec (
        .word_in  (cmd_word),
        .loop_flag(loop_q),
        .dec      (dec),
        .word_out (cmd_out)
    );

    cis_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .words_ready(words_ready),
        .resume     (resume),
        .exec_done  (exec_done),
        .want_stall (dec.want_stall),
        .state_q    (state_q),
        .exec_en    (exec_en),
        .stall_go   (stall_go),
        .leave_stall(leave_stall)
    );

    cis_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_stall(stall_go),
        .clr_pis  (leave_stall),
        .int_clr  (int_clr),
        .consume  (exec_en && dec.consume),
        .loop_q   (loop_q),
        .int_q    (stat_int),
        .pis_q    (stat_pis)
    );

    assign proc_state = state_q;

    // R5
    masked_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && loop_q && cmd_word[INTR_BIT] && !dec.is_mark) |-> !cmd_out[INTR_BIT]);

    // R7
    mark_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && dec.is_mark) |-> (cmd_out == cmd_word));

    // R2
    pis_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_pis |-> (proc_state == 2'd2));
endmodule

// File: tb/sim_cmd_intr_stall_ctrl.sv
module sim_cmd_intr_stall_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] MARK = 7'h31;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        words_ready = 1'b1;
    logic        resume = 1'b0;
    logic        int_clr = 1'b0;
    logic        exec_done = 1'b0;
    logic [31:0] cmd_out;
    logic        exec_en;
    logic [1:0]  proc_state;
    logic        stat_int;
    logic        stat_pis;

    int n_run = 0;
    int n_fail = 0;
    logic exp_loop = 1'b0;
    logic exp_int = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmd_intr_stall_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .words_ready(words_ready), .resume(resume), .int_clr(int_clr),
        .exec_done(exec_done), .cmd_out(cmd_out), .exec_en(exec_en),
        .proc_state(proc_state), .stat_int(stat_int), .stat_pis(stat_pis)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_xfer;
        @(negedge clk);
        cmd_valid = 1'b0;
        exec_done = 1'b1;
        tick();
        chk("R9 idle after done", 32'(proc_state), 32'd0);
        @(negedge clk);
        exec_done = 1'b0;
    endtask

    task automatic run_word(input logic [31:0] w, input logic clr_same);
        logic mark, stall;
        mark  = (w[30:24] == MARK);
        stall = w[31] && !mark && !exp_loop;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        int_clr   = clr_same;
        #1;
        if (stall) begin
            chk("R2 no dispatch", 32'(exec_en), 32'd0);
            tick();
            int_clr = 1'b0;
            exp_int = 1'b1;
            exp_loop = 1'b1;
            chk("R2 state stall", 32'(proc_state), 32'd2);
            chk("R2/R10 int set", 32'(stat_int), 32'd1);
            chk("R2 pis set", 32'(stat_pis), 32'd1);
            tick();
            chk("R3 held stall", 32'(proc_state), 32'd2);
            @(negedge clk);
            #1;
            chk("R3 no exec", 32'(exec_en), 32'd0);
            resume = 1'b1;
            tick();
            chk("R4 pis clear", 32'(stat_pis), 32'd0);
            chk("R4 idle", 32'(proc_state), 32'd0);
            chk("R4 int kept", 32'(stat_int), 32'd1);
            @(negedge clk);
            resume = 1'b0;
            #1;
            chk("R5 redecode exec", 32'(exec_en), 32'd1);
            chk("R5 masked word", cmd_out, w & 32'h7fff_ffff);
            exp_loop = 1'b0;
            tick();
            chk("R5 no restall", 32'(proc_state), 32'd3);
            @(negedge clk);
            int_clr = 1'b1;
            tick();
            exp_int = 1'b0;
            chk("R10 int cleared", 32'(stat_int), 32'd0);
            @(negedge clk);
            int_clr = 1'b0;
        end else begin
            logic [31:0] ew;
            ew = (w[31] && !mark && exp_loop) ? (w & 32'h7fff_ffff) : w;
            if (w[31] && !mark) exp_loop = 1'b0;
            chk(mark ? "R7 mark exec" : "R6 exec", 32'(exec_en), 32'd1);
            chk(mark ? "R7 mark word" : "R6 word", cmd_out, ew);
            tick();
            int_clr = 1'b0;
            if (clr_same) exp_int = 1'b0;
            chk("R6 xfer", 32'(proc_state), 32'd3);
            chk("R7 int untouched", 32'(stat_int), 32'(exp_int));
            chk("R7 pis untouched", 32'(stat_pis), 32'd0);
        end
        finish_xfer();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog got=hang exp=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 state", 32'(proc_state), 32'd0);
        chk("R1 int", 32'(stat_int), 32'd0);
        chk("R1 pis", 32'(stat_pis), 32'd0);
        chk("R1 exec", 32'(exec_en), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int op = 0; op < 128; op++) begin
            for (int f = 0; f < 2; f++) begin
                run_word({f[0], op[6:0], 24'(op * 40503 + f * 977)}, 1'b0);
            end
        end

        // R10 collision: clear and stall entry in the same cycle
        run_word(32'h8500_1234, 1'b1);

        // R8 wait for operand words
        @(negedge clk);
        words_ready = 1'b0;
        cmd_valid = 1'b1;
        cmd_word = 32'h0a00_0042;
        #1;
        chk("R8 no exec while waiting", 32'(exec_en), 32'd0);
        tick();
        chk("R8 wait state", 32'(proc_state), 32'd1);
        @(negedge clk);
        words_ready = 1'b1;
        #1;
        chk("R8 exec on ready", 32'(exec_en), 32'd1);
        tick();
        chk("R8 xfer", 32'(proc_state), 32'd3);
        finish_xfer();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule